// File: doc/BRIEF.md
# Multifunction ALU with Class Select

This block is the combinational 32-bit execution unit of a small load/store processor. Each instruction's decoder drives one 8-bit control word. That word first names a function class: upper-immediate load, set-less-than, add/subtract or bitwise logic. Sub-fields inside the word then pick the exact operation within that class. There are two 32-bit operands and a 16-bit immediate used only by the upper-immediate load.

Besides the 32-bit result, the block reports a zero flag and the result's sign bit. Equal/not-equal branches use the zero flag, and branch-on-negative uses the sign bit. Set-less-than is not a separate comparator. It comes from the subtractor's output, with a correction for overflow so that signed operands of opposite sign order correctly.

A small fixed-amount shifter stage follows the adder. It is active only in the arithmetic class.

Top module: `alu_core`

## Requirements
- R1: The control word is laid out as bits 7:6 function class, bit 5 add/subtract select, bits 4:2 shift code and bits 1:0 logic function.
- R2: Class 00 (upper-immediate load) gives a result whose bits 31:16 hold the 16-bit immediate and whose bits 15:0 are zero.
- R3: Class 10 (arithmetic) with shift code 000 gives a+b modulo 2^32 when the select bit is 0, and a-b modulo 2^32 when it is 1.
- R4: Class 01 (set-less-than) with the select bit at 1 gives 1 when a is less than b as signed 32-bit integers, and 0 otherwise. This holds across sign boundaries, for example 0x80000000 against 0x7FFFFFFF gives 1.
- R5: Class 11 (logic) gives a AND b for function 00, a OR b for 01, a XOR b for 10 and NOT(a OR b) for 11.
- R6: The zero flag is 1 exactly when all 32 result bits are 0. For example, a-b with a equal to b raises it.
- R7: The sign output always equals bit 31 of the result.
- R8: In class 10 the shift code acts on the add/subtract output. Code bit 2 picks the shift amount: 1 when 0, 8 when 1. Code bits 1:0 pick the operation: 00 no shift, 01 shift left, 10 logical shift right, 11 arithmetic shift right.
- R9: In classes 00, 01 and 11 the shift code has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| upper_imm | input | 16 | Immediate for the upper-immediate load |
| ctrl | input | 8 | Control word (class, select, shift code, logic function) |
| result | output | 32 | Selected result |
| zero | output | 1 | High when result is all zeros |
| neg | output | 1 | Result bit 31 |

## Verification
The immediate assertions check several properties on every evaluation:
- the upper-immediate load leaves the low half clear;
- set-less-than returns only 0 or 1;
- an addition is undone by subtracting b, and subtracting equal operands gives zero;
- a zero shift code passes the value unchanged;
- a NOR result never has a bit set where a has one.

Only the bench's sweeps can show the arithmetic results, the signed ordering across the sign boundary, each shift variant and the fact that the shift code is ignored outside the arithmetic class. The bench runs corner and pseudo-random operand pairs against a model computed from the requirements.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 16;

    typedef enum logic [1:0] {
        CLS_UPPER = 2'b00,
        CLS_SLT   = 2'b01,
        CLS_ARITH = 2'b10,
        CLS_LOGIC = 2'b11
    } fn_class_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_NOR = 2'b11
    } logic_fn_e;

    typedef struct packed {
        fn_class_e fclass;
        logic      subtract;
        logic [2:0] shift_code;
        logic_fn_e lfn;
    } alu_ctrl_t;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              zero;
        logic              neg;
    } alu_out_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         subtract,
    output logic [W-1:0] sum,
    output logic         less
);
    logic [W-1:0] b_eff;
    logic         ovf;

    always_comb begin
        b_eff = subtract ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, subtract};
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        less  = sum[W-1] ^ ovf;
    end

    // R3: an addition is undone by subtracting b
    always_comb begin
        if (!subtract) a_r3_add_inverse: assert ((sum - b) == a);
        if (subtract && (a == b)) a_r6_self_diff_zero: assert (sum == '0);
    end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    lfn,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (lfn)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = ~(a | b);
        endcase
    end

    // R5: NOR never sets a bit where a has one
    always_comb begin
        if (lfn == LG_NOR) a_r5_nor_clears_a: assert ((y & a) == '0);
    end
endmodule

// File: rtl/alu_shift_stage.sv
module alu_shift_stage #(
    parameter int W     = 32,
    parameter int SH_LO = 1,
    parameter int SH_HI = 8
) (
    input  logic [W-1:0] din,
    input  logic [2:0]   code,
    output logic [W-1:0] dout
);
    localparam int N_AMT = 2;

    logic [W-1:0] shl [N_AMT];
    logic [W-1:0] shr [N_AMT];
    logic [W-1:0] sra [N_AMT];

    for (genvar i = 0; i < N_AMT; i++) begin : g_amt
        localparam int S = (i == 0) ? SH_LO : SH_HI;
        assign shl[i] = din << S;
        assign shr[i] = din >> S;
        assign sra[i] = W'($signed(din) >>> S);
    end

    always_comb begin
        unique case (code[1:0])
            2'b01:   dout = code[2] ? shl[1] : shl[0];
            2'b10:   dout = code[2] ? shr[1] : shr[0];
            2'b11:   dout = code[2] ? sra[1] : sra[0];
            default: dout = din;
        endcase
    end

    // R8: the no-shift codes pass the value unchanged
    always_comb begin
        if (code[1:0] == 2'b00) a_r8_pass_through: assert (dout == din);
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int IW    = IMM_W,
    parameter int SH_LO = 1,
    parameter int SH_HI = 8
) (
    input  logic [W-1:0]  opnd_a,
    input  logic [W-1:0]  opnd_b,
    input  logic [IW-1:0] upper_imm,
    input  logic [7:0]    ctrl,
    output logic [W-1:0]  result,
    output logic          zero,
    output logic          neg
);
    localparam int LOW_W = W - IW;

    alu_ctrl_t    c;
    logic [W-1:0] sum_w;
    logic         less_w;
    logic [W-1:0] shifted_w;
    logic [W-1:0] logic_w;
    logic [W-1:0] res_d;

    assign c = alu_ctrl_t'(ctrl);

    alu_addsub #(.W(W)) u_addsub (
        .a        (opnd_a),
        .b        (opnd_b),
        .subtract (c.subtract),
        .sum      (sum_w),
        .less     (less_w)
    );

    alu_shift_stage #(.W(W), .SH_LO(SH_LO), .SH_HI(SH_HI)) u_shift (
        .din  (sum_w),
        .code (c.shift_code),
        .dout (shifted_w)
    );

    alu_logic_unit #(.W(W)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .lfn (c.lfn),
        .y   (logic_w)
    );

    always_comb begin
        unique case (c.fclass)
            CLS_UPPER: res_d = {upper_imm, {LOW_W{1'b0}}};
            CLS_SLT:   res_d = {{(W-1){1'b0}}, less_w};
            CLS_ARITH: res_d = shifted_w;
            default:   res_d = logic_w;
        endcase
    end

    assign result = res_d;
    assign zero   = ~|res_d;
    assign neg    = res_d[W-1];

    // R2 / R4: class-specific shape of the result
    always_comb begin
        if (c.fclass == CLS_UPPER) a_r2_low_half_clear: assert (result[LOW_W-1:0] == '0);
        if (c.fclass == CLS_SLT)   a_r4_slt_single_bit: assert (result[W-1:1] == '0);
    end
endmodule

// File: tb/alu_core_tb.sv
module alu_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a, b;
    logic [15:0] imm;
    logic [7:0]  ctrl;
    logic [31:0] result;
    logic        zero, neg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] vals [16];

    always #4 clk = ~clk;

    alu_core u_dut (
        .opnd_a    (a),
        .opnd_b    (b),
        .upper_imm (imm),
        .ctrl      (ctrl),
        .result    (result),
        .zero      (zero),
        .neg       (neg)
    );

    function automatic logic [31:0] shift_ref(logic [31:0] v, logic [2:0] code);
        int amt = code[2] ? 8 : 1;
        case (code[1:0])
            2'b01:   return v << amt;
            2'b10:   return v >> amt;
            2'b11:   return 32'($signed(v) >>> amt);
            default: return v;
        endcase
    endfunction

    function automatic logic [31:0] model(logic [31:0] x, logic [31:0] y,
                                          logic [15:0] im, logic [7:0] cw);
        logic [31:0] s;
        s = cw[5] ? (x - y) : (x + y);
        case (cw[7:6])
            2'b00: return {im, 16'h0000};
            2'b01: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            2'b10: return shift_ref(s, cw[4:2]);
            default: begin
                case (cw[1:0])
                    2'b00:   return x & y;
                    2'b01:   return x | y;
                    2'b10:   return x ^ y;
                    default: return ~(x | y);
                endcase
            end
        endcase
    endfunction

    task automatic apply_check(string req, logic [31:0] x, logic [31:0] y,
                               logic [15:0] im, logic [7:0] cw);
        logic [31:0] exp;
        @(negedge clk);
        a = x; b = y; imm = im; ctrl = cw;
        #2;
        exp = model(x, y, im, cw);
        n_tests++;
        if (result !== exp || zero !== (exp == 32'd0) || neg !== exp[31]) begin
            n_fail++;
            $display("FAIL %s ctrl=%02h a=%08h b=%08h: got r=%08h z=%0b n=%0b, expected r=%08h z=%0b n=%0b",
                     req, cw, x, y, result, zero, neg, exp, (exp == 32'd0), exp[31]);
        end
    endtask

    initial begin
        logic [31:0] lcg;
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
        vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h8000_0000;
        vals[4] = 32'h7FFF_FFFF; vals[5] = 32'h8000_0001;
        vals[6] = 32'hFFFF_FFFE; vals[7] = 32'h5555_AAAA;
        lcg = 32'h1234_5678;
        for (int i = 8; i < 16; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            vals[i] = lcg;
        end
        a = '0; b = '0; imm = '0; ctrl = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 R2 R6: initial state, zero immediate gives zero result
        apply_check("R2_R6_init", 32'h0, 32'h0, 16'h0, 8'h00);

        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                // R2 upper-immediate load, class 00
                apply_check("R2", vals[i], vals[j], vals[j][31:16], 8'b00_0_000_00);
                // R4 set-less-than, class 01 subtract
                apply_check("R4", vals[i], vals[j], 16'h0, 8'b01_1_000_00);
                // R3 add / subtract, class 10; R6 R7 flags
                apply_check("R3_add", vals[i], vals[j], 16'h0, 8'b10_0_000_00);
                apply_check("R3_sub", vals[i], vals[j], 16'h0, 8'b10_1_000_00);
                // R5 logic functions, class 11
                for (int f = 0; f < 4; f++)
                    apply_check("R5", vals[i], vals[j], 16'h0, {2'b11, 1'b0, 3'b000, 2'(f)});
            end
        end

        // R4 corner: most negative against most positive
        apply_check("R4_corner", 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 8'b01_1_000_00);
        apply_check("R4_corner_rev", 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 8'b01_1_000_00);
        // R6: x - x raises zero
        apply_check("R6_self_sub", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h0, 8'b10_1_000_00);
        // R7: negative sum drives sign
        apply_check("R7_neg", 32'h0, 32'h1, 16'h0, 8'b10_1_000_00);

        // R8: every shift code applied to add and subtract outputs
        for (int s = 0; s < 8; s++) begin
            for (int i = 0; i < 16; i++) begin
                apply_check("R8_add", vals[i], vals[15 - i], 16'h0, {2'b10, 1'b0, 3'(s), 2'b00});
                apply_check("R8_sub", vals[i], vals[15 - i], 16'h0, {2'b10, 1'b1, 3'(s), 2'b00});
            end
        end

        // R9: shift code has no effect outside class 10
        for (int s = 1; s < 8; s++) begin
            for (int i = 0; i < 16; i++) begin
                apply_check("R9_upper", vals[i], vals[i], vals[i][15:0], {2'b00, 1'b0, 3'(s), 2'b00});
                apply_check("R9_slt", vals[i], vals[15 - i], 16'h0, {2'b01, 1'b1, 3'(s), 2'b00});
                apply_check("R9_logic", vals[i], vals[15 - i], 16'h0, {2'b11, 1'b0, 3'(s), 2'(i)});
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule